// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. It drives a chip select, a serial clock and a serial data line toward the memory and samples the memory's return line. A command port takes one of seven operations (word read, word write, word erase, erase of the whole array, write of one value to the whole array, programming unlock and programming lock), together with an address and a write word. The controller builds the serial instruction, shifts it out, and for reads collects the returned word once the leading zero has been dropped.

After any programming command the controller drops chip select for a set number of system clocks so that the memory starts its internal cycle. It then reselects the memory and watches the return line until it reads high (ready). It then clocks a single 1 into the memory so that the shared return line is released, deselects the memory and signals completion. If ready never comes within a set number of clocks, the controller deselects the memory and flags a timeout. Every command ends with chip select held low for the minimum low time before the done pulse is raised.

Top module: `mw_eeprom_host`

## Requirements
- R1: A frame sent on ser_o is a 1 start bit, then a 2-bit opcode, then ADDR_W address bits, and for word write and write-all it is followed by DATA_W data bits. Every field goes out most significant bit first. The opcodes are read 10, write 01 and erase 11. op_i codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 unlock and 6 lock.
- R2: ser_o changes only while sclk_o is low, so it is stable on every rising sclk_o edge.
- R3: On a read, the bit the memory returns with the last address bit is a zero and is discarded. The next DATA_W bits, sampled on the falling sclk_o edges, form rdata_o MSB first, which is valid when done_o pulses.
- R4: The four special commands use opcode 00, and the top two address bits select the command: 11 unlock, 00 lock, 10 erase-all, 01 write-all. The rest of the address bits are 0.
- R5: Once chip select has been dropped, sel_o stays low for at least CS_LOW_CYC system clocks before it rises again or done_o is raised.
- R6: After a programming frame and the low gap, sel_o rises and ser_i is polled. Low means busy and high means ready, and done_o never comes while the memory is still busy.
- R7: When ready is seen, the controller sends one sclk_o cycle with ser_o high while still selected, and then drops sel_o.
- R8: Each sclk_o high phase lasts exactly HALF_DIV system clocks, and each low phase inside a selection lasts at least HALF_DIV. sclk_o is low whenever sel_o is low.
- R9: If ready is not seen within POLL_MAX clocks of polling, sel_o drops and timeout_o is set, and it stays set through done_o until the next accepted request.
- R10: busy_o is high from an accepted request until the cycle of the single-cycle done_o pulse. req_i is ignored while busy_o is high.
- R11: During reset sel_o, sclk_o, ser_o, busy_o, done_o and timeout_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command request, accepted when not busy |
| op_i | input | 3 | Operation code |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word for write or write-all |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last command never saw ready |
| rdata_o | output | DATA_W | Word from the last read |
| sel_o | output | 1 | Memory chip select |
| sclk_o | output | 1 | Serial clock to the memory |
| ser_o | output | 1 | Serial data to the memory |
| ser_i | input | 1 | Serial data and status from the memory |

## Verification
The bench runs a serial memory model that decodes frames bit by bit and holds its line low for a busy period after every write or erase. Read-back exposes a controller that drops or keeps the leading zero, because its words come back shifted by one bit. Writes at address 0 and at the top address catch a wrong field order. Writes attempted while locked must leave the data unchanged, which a wrong special-command code would break. The bench measures the chip-select low gap and the clock phase lengths, counts released status phases to catch a missing or misplaced release bit, and holds the model busy forever to force the timeout path. A second request issued mid-command must not produce an extra done.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_ERASE     = 3'd2,
    OP_CLEAR_ALL = 3'd3,
    OP_FILL      = 3'd4,
    OP_UNLOCK    = 3'd5,
    OP_LOCK      = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_SETTLE,
    ST_POLL
  } st_e;

  function automatic logic is_prog(op_e op);
    return (op == OP_WRITE) || (op == OP_ERASE) || (op == OP_CLEAR_ALL) || (op == OP_FILL);
  endfunction

  function automatic logic has_data(op_e op);
    return (op == OP_WRITE) || (op == OP_FILL);
  endfunction
endpackage

// File: rtl/mw_sclk_gen.sv
module mw_sclk_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(HALF_DIV - 1));
  assign rise_o = tick && !sclk_q;
  assign fall_o = tick && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  rise_fall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> (sclk_o && !fall_o));
endmodule

// File: rtl/mw_timer.sv
module mw_timer #(
  parameter int unsigned MAXV = 16,
  parameter int unsigned W    = $clog2(MAXV + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // R5
  load_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !zero_o);
endmodule

// File: rtl/mw_eeprom_host.sv
module mw_eeprom_host #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned HALF_DIV   = 4,
  parameter int unsigned CS_LOW_CYC = 10,
  parameter int unsigned POLL_MAX   = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sel_o,
  output logic              sclk_o,
  output logic              ser_o,
  input  logic              ser_i
);
  import mw_pkg::*;

  localparam int unsigned CMD_W   = 3 + ADDR_W;
  localparam int unsigned FRAME_W = CMD_W + DATA_W;
  localparam int unsigned BCW     = $clog2(FRAME_W + 1);
  localparam int unsigned TMAX0   = (CS_LOW_CYC > HALF_DIV) ? CS_LOW_CYC : HALF_DIV;
  localparam int unsigned TMAX    = (POLL_MAX > TMAX0) ? POLL_MAX : TMAX0;
  localparam int unsigned TW      = $clog2(TMAX + 1);

  st_e                st_q;
  op_e                op_q, op_in;
  logic [FRAME_W-1:0] tx_q, frame;
  logic [BCW-1:0]     nbits_q, bcnt_q, nb;
  logic [DATA_W-1:0]  rx_q;
  logic               prog_q, to_q, sel_q, done_q;
  logic [1:0]         opc;
  logic [ADDR_W-1:0]  afield;
  logic               sh_rise, sh_fall, frame_end;
  logic               tmr_load, tmr_zero;
  logic [TW-1:0]      tmr_val;

  mw_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (st_q == ST_SHIFT),
    .sclk_o(sclk_o), .rise_o (sh_rise), .fall_o (sh_fall)
  );

  mw_timer #(.MAXV(TMAX), .W(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load),
    .val_i (tmr_val), .zero_o (tmr_zero)
  );

  // instruction build
  always_comb begin
    op_in  = op_e'(op_i);
    opc    = 2'b00;
    afield = {2'b00, {(ADDR_W-2){1'b0}}};
    case (op_in)
      OP_READ:      begin opc = 2'b10; afield = addr_i; end
      OP_WRITE:     begin opc = 2'b01; afield = addr_i; end
      OP_ERASE:     begin opc = 2'b11; afield = addr_i; end
      OP_CLEAR_ALL: afield = {2'b10, {(ADDR_W-2){1'b0}}};
      OP_FILL:      afield = {2'b01, {(ADDR_W-2){1'b0}}};
      OP_UNLOCK:    afield = {2'b11, {(ADDR_W-2){1'b0}}};
      default:      afield = {2'b00, {(ADDR_W-2){1'b0}}};
    endcase
    frame = {1'b1, opc, afield, has_data(op_in) ? wdata_i : {DATA_W{1'b0}}};
    nb    = (op_in == OP_READ || has_data(op_in)) ? BCW'(FRAME_W) : BCW'(CMD_W);
  end

  assign frame_end = (st_q == ST_SHIFT) && sh_fall && (bcnt_q == nbits_q);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (frame_end) begin
      tmr_load = 1'b1; tmr_val = TW'(CS_LOW_CYC);
    end else if (st_q == ST_GAP && tmr_zero && prog_q) begin
      tmr_load = 1'b1; tmr_val = TW'(HALF_DIV);
    end else if (st_q == ST_SETTLE && tmr_zero) begin
      tmr_load = 1'b1; tmr_val = TW'(POLL_MAX);
    end else if (st_q == ST_POLL && !ser_i && tmr_zero) begin
      tmr_load = 1'b1; tmr_val = TW'(CS_LOW_CYC);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_LOCK;
      tx_q    <= '0;
      nbits_q <= '0;
      bcnt_q  <= '0;
      rx_q    <= '0;
      prog_q  <= 1'b0;
      to_q    <= 1'b0;
      sel_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_i) begin
          op_q    <= op_in;
          tx_q    <= frame;
          nbits_q <= nb;
          bcnt_q  <= '0;
          prog_q  <= is_prog(op_in);
          to_q    <= 1'b0;
          sel_q   <= 1'b1;
          st_q    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sh_rise) bcnt_q <= bcnt_q + 1'b1;
          if (sh_fall) begin
            // bit returned with the last address bit is the dummy zero
            if (op_q == OP_READ && bcnt_q > BCW'(CMD_W))
              rx_q <= {rx_q[DATA_W-2:0], ser_i};
            if (frame_end) begin
              sel_q <= 1'b0;
              tx_q  <= '0;
              st_q  <= ST_GAP;
            end else begin
              tx_q <= tx_q << 1;
            end
          end
        end
        ST_GAP: if (tmr_zero) begin
          if (prog_q) begin
            sel_q <= 1'b1;
            st_q  <= ST_SETTLE;
          end else begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_SETTLE: if (tmr_zero) st_q <= ST_POLL;
        ST_POLL: begin
          if (ser_i) begin
            // ready: one clock with a 1 releases the shared line
            prog_q  <= 1'b0;
            tx_q    <= {1'b1, {(FRAME_W-1){1'b0}}};
            nbits_q <= BCW'(1);
            bcnt_q  <= '0;
            st_q    <= ST_SHIFT;
          end else if (tmr_zero) begin
            to_q   <= 1'b1;
            prog_q <= 1'b0;
            sel_q  <= 1'b0;
            st_q   <= ST_GAP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = to_q;
  assign rdata_o   = rx_q;
  assign sel_o     = sel_q;
  assign ser_o     = tx_q[FRAME_W-1];

  // chip-select low time, counted independently
  logic [TW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         low_cnt_q <= TW'(CS_LOW_CYC);
    else if (sel_q)                      low_cnt_q <= '0;
    else if (low_cnt_q != TW'(CS_LOW_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  // R5
  sel_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_o) |-> (low_cnt_q == TW'(CS_LOW_CYC)));

  // R8
  sclk_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> !sclk_o);

  // R2
  ser_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(ser_o));

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_POLL && ser_i) |=> (ser_o && sel_o));

  // R9
  timeout_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !sel_o);

  // R10
  done_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/mw_eeprom_host_tb.sv
module mw_eeprom_host_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int HALF_DIV = 4;
  localparam int CS_LOW_CYC = 10;
  localparam int POLL_MAX = 400;
  localparam int BUSY_CYC = 60;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni;
  logic req_i;
  logic [2:0] op_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic busy_o, done_o, timeout_o, sel_o, sclk_o, ser_o, ser_i;
  logic [DW-1:0] rdata_o;

  always #10 clk = ~clk;

  mw_eeprom_host #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(HALF_DIV),
                   .CS_LOW_CYC(CS_LOW_CYC), .POLL_MAX(POLL_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .op_i(op_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
    .rdata_o(rdata_o), .sel_o(sel_o), .sclk_o(sclk_o), .ser_o(ser_o), .ser_i(ser_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // serial memory model
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic sel_prev, sclk_prev, started, rd_mode, m_we, stat_m, pend_stat, stuck;
  int cnt, busy_cnt, rel_ok;
  logic [31:0] sreg, nxt;
  logic [DW-1:0] rd_word;
  logic do_bit;
  logic [1:0] f_opc, f_code;
  logic [AW-1:0] f_a;

  assign ser_i = stat_m ? (busy_cnt == 0 && !stuck) : (rd_mode ? do_bit : 1'b1);

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(i * 16'h0101) ^ 16'h5A5A;
      shadow[i] = mem[i];
    end
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      sel_prev <= 0; sclk_prev <= 0; started <= 0; rd_mode <= 0; m_we <= 0;
      stat_m <= 0; pend_stat <= 0; cnt <= 0; busy_cnt <= 0; rel_ok <= 0;
      sreg <= 0; rd_word <= 0; do_bit <= 1;
    end else begin
      sel_prev <= sel_o; sclk_prev <= sclk_o;
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (!sel_o) begin
        if (sel_prev && !stat_m && started) begin
          if (cnt == 2 + AW) begin
            f_opc = sreg[AW+1:AW]; f_a = sreg[AW-1:0]; f_code = f_a[AW-1:AW-2];
            if (f_opc == 2'b11) begin
              if (m_we) begin mem[f_a] <= '1; busy_cnt <= BUSY_CYC; end
              pend_stat <= 1;
            end else if (f_opc == 2'b00 && f_code == 2'b10) begin
              if (m_we) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
                busy_cnt <= BUSY_CYC;
              end
              pend_stat <= 1;
            end else if (f_opc == 2'b00 && f_code == 2'b11) m_we <= 1;
            else if (f_opc == 2'b00 && f_code == 2'b00) m_we <= 0;
          end else if (cnt == 2 + AW + DW) begin
            f_opc = sreg[AW+DW+1:AW+DW]; f_a = sreg[AW+DW-1:DW]; f_code = f_a[AW-1:AW-2];
            if (f_opc == 2'b01) begin
              if (m_we) begin mem[f_a] <= sreg[DW-1:0]; busy_cnt <= BUSY_CYC; end
              pend_stat <= 1;
            end else if (f_opc == 2'b00 && f_code == 2'b01) begin
              if (m_we) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= sreg[DW-1:0];
                busy_cnt <= BUSY_CYC;
              end
              pend_stat <= 1;
            end
          end
        end
        if (sel_prev) stat_m <= 0;
        started <= 0; rd_mode <= 0; cnt <= 0; sreg <= 0;
      end else begin
        if (!sel_prev && pend_stat) begin stat_m <= 1; pend_stat <= 0; end
        if (sclk_o && !sclk_prev) begin
          if (stat_m) begin
            if (ser_o) rel_ok <= rel_ok + 1;
            stat_m <= 0;
          end else if (!started) begin
            if (ser_o) begin started <= 1; cnt <= 0; sreg <= 0; end
          end else begin
            nxt = {sreg[30:0], ser_o};
            sreg <= nxt;
            cnt <= cnt + 1;
            if (cnt + 1 == 2 + AW && nxt[AW+1:AW] == 2'b10) begin
              rd_mode <= 1; do_bit <= 0; rd_word <= mem[nxt[AW-1:0]];
            end else if (rd_mode) begin
              do_bit <= rd_word[DW-1]; rd_word <= rd_word << 1;
            end
          end
        end
      end
    end
  end

  // scoreboard
  typedef struct {bit rd; logic [DW-1:0] val; bit to; bit prog; string tag;} exp_t;
  exp_t q[$];
  bit we_exp = 0;
  int n_prog = 0;

  always @(negedge clk) begin
    if (rst_ni && done_o) begin
      if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        exp_t it;
        it = q.pop_front();
        chk(timeout_o == it.to, "R9", {it.tag, " timeout flag"}, 32'(timeout_o), 32'(it.to));
        if (it.rd) chk(rdata_o == it.val, it.tag, "read word", 32'(rdata_o), 32'(it.val));
        if (it.prog && !it.to) chk(busy_cnt == 0, "R6", "done while busy", busy_cnt, 0);
      end
    end
  end

  // timing monitors
  int low_len = 100, sk_len = 0, bad_r5 = 0, bad_r8 = 0, bad_r2 = 0;
  logic sk_l = 0, sel_l = 0, ser_l = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (sel_o && !sel_l && low_len < CS_LOW_CYC) bad_r5++;
      low_len = sel_o ? 0 : low_len + 1;
      if (!sel_o && sclk_o) bad_r8++;
      if (sel_o && sel_l) begin
        if (sclk_o != sk_l) begin
          if (sk_l && sk_len != HALF_DIV) bad_r8++;
          if (!sk_l && sk_len < HALF_DIV) bad_r8++;
          if (sclk_o && ser_o != ser_l) bad_r2++;
          sk_len = 1;
        end else sk_len++;
      end else sk_len = sel_o ? 1 : 0;
    end
    sk_l = sclk_o; sel_l = sel_o; ser_l = ser_o;
  end

  function automatic bit prog_op(input logic [2:0] o);
    return o inside {3'd1, 3'd2, 3'd3, 3'd4};
  endfunction

  task automatic cmd(input logic [2:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input string tag, input bit poke = 0);
    exp_t it;
    while (busy_o) @(negedge clk);
    it.rd = (o == 3'd0); it.val = shadow[a]; it.prog = prog_op(o);
    it.to = stuck && it.prog && we_exp; it.tag = tag;
    if (we_exp) begin
      case (o)
        3'd1: shadow[a] = d;
        3'd2: shadow[a] = '1;
        3'd3: for (int i = 0; i < DEPTH; i++) shadow[i] = '1;
        3'd4: for (int i = 0; i < DEPTH; i++) shadow[i] = d;
        default: ;
      endcase
    end
    if (o == 3'd5) we_exp = 1;
    if (o == 3'd6) we_exp = 0;
    if (it.prog && !it.to) n_prog++;
    q.push_back(it);
    req_i = 1; op_i = o; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0;
    if (poke) begin
      repeat (30) @(negedge clk);
      req_i = 1; op_i = 3'd0; addr_i = '0;
      @(negedge clk);
      req_i = 0;
    end
    while (q.size() != 0) @(negedge clk);
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        chk(!busy_o, "R10", "request during busy started a command", 32'(busy_o), 0);
      end
    end
  endtask

  initial begin
    rst_ni = 0; req_i = 0; op_i = 0; addr_i = 0; wdata_i = 0; stuck = 0;
    repeat (3) @(negedge clk);
    chk(!sel_o && !sclk_o && !ser_o, "R11", "serial pins in reset", {sel_o, sclk_o, ser_o}, 0);
    chk(!busy_o && !done_o && !timeout_o, "R11", "status in reset", {busy_o, done_o, timeout_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    cmd(3'd0, 6'd5, 0, "R3");
    cmd(3'd1, 6'd5, 16'h1234, "R4 locked write");
    cmd(3'd0, 6'd5, 0, "R4");
    cmd(3'd5, 6'd0, 0, "R4 unlock");
    cmd(3'd1, 6'd5, 16'h1234, "R6 write");
    cmd(3'd0, 6'd5, 0, "R1");
    cmd(3'd1, 6'd63, 16'h8001, "R1 write");
    cmd(3'd0, 6'd63, 0, "R1");
    cmd(3'd1, 6'd0, 16'hC3A5, "R1 write");
    cmd(3'd0, 6'd0, 0, "R2");
    cmd(3'd2, 6'd5, 0, "R6 erase");
    cmd(3'd0, 6'd5, 0, "R3");
    cmd(3'd4, 6'd0, 16'hA55A, "R4 write-all");
    cmd(3'd0, 6'd17, 0, "R4");
    cmd(3'd0, 6'd62, 0, "R4");
    cmd(3'd3, 6'd0, 0, "R4 erase-all");
    cmd(3'd0, 6'd40, 0, "R4");
    cmd(3'd1, 6'd9, 16'h0F0F, "R10 write", 1);
    cmd(3'd0, 6'd9, 0, "R10");
    cmd(3'd6, 6'd0, 0, "R4 lock");
    cmd(3'd1, 6'd9, 16'h1111, "R4 locked write");
    cmd(3'd0, 6'd9, 0, "R4");
    cmd(3'd5, 6'd0, 0, "R4 unlock");
    stuck = 1;
    cmd(3'd1, 6'd3, 16'hBEEF, "R9");
    stuck = 0;
    cmd(3'd0, 6'd3, 0, "R9");
    repeat (5) @(negedge clk);
    chk(rel_ok == n_prog, "R7", "released status phases", rel_ok, n_prog);
    chk(bad_r5 == 0, "R5", "short select gaps", bad_r5, 0);
    chk(bad_r8 == 0, "R8", "clock phase violations", bad_r8, 0);
    chk(bad_r2 == 0, "R2", "data moved at rising clock", bad_r2, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule